// File: doc/BRIEF.md
# Scanline and Frame Timing Generator

This block derives horizontal-line and frame timing straight from the system clock. The number of clocks per line is not a whole number. A fixed-point phase accumulator with 12 fraction bits sets the length of each line. It carries the fraction left over from one line into the next, so that over time the average line length matches the programmed rate exactly. Two video standards are supported. The default 60 Hz rate uses an increment of 8791293 (about 2146.31 clocks per line) and 263 lines per frame. The default 50 Hz rate uses 8864320 (about 2164.14 clocks) and 313 lines.

On top of the line pacing, the block does four more jobs:
- It numbers the lines within the frame.
- It raises a one-cycle vertical-blank interrupt when line 240 begins.
- It keeps a field flag. The flag is cleared at vertical blank and, in interlaced operation, reloaded at each frame wrap from the parity of a frame counter.
- It emits a one-cycle audio-update tick once every 32 lines.

The standard-select input is looked at only at the moment a frame wraps. A frame therefore never mixes the two line counts.

Top module: `scan_timing_gen`

## Requirements
- R1: `line_tick_o` is high for exactly one clock at the end of each line. Counting the state right after reset as cycle 0, the k-th tick (k = 1, 2, ...) falls in cycle floor(S_k / 2^FRAC_W) - 1. Here S_k is the sum of the increments of lines 1..k, and each line uses the increment of the standard that line belongs to. The fraction is thus carried from line to line.
- R2: `line_o` holds the current line number and changes only in the cycle after a line tick. It steps by one, and after the last line of the frame it returns to 0. A frame has LINES_60 lines (263) when standard 0 is active and LINES_50 lines (313) when standard 1 is active.
- R3: `std_sel_i` (0 = 60 Hz standard, 1 = 50 Hz standard) is sampled only at the line tick that ends a frame. The sampled standard sets both the line count and the per-line increment from the first line of the new frame. Changes at any other time have no effect.
- R4: `vblank_irq_o` is a one-cycle pulse in the first cycle in which `line_o` equals VBL_LINE (240). It does not occur at any other time.
- R5: `field_o` is cleared when line VBL_LINE begins. At each frame wrap, an internal frame counter increments. `field_o` then takes the counter's least significant bit if `interlace_i` is 1 at that tick, and 0 otherwise. `field_o` changes at no other time.
- R6: `audio_tick_o` is a one-cycle pulse in the cycle after every AUDIO_LINES-th line tick (32), counted from reset. Its count does not restart at frame wrap.
- R7: While `rst_n` is low at a clock edge, the line number, frame counter, field flag and all pulses are cleared. The active standard becomes 0, and the phase accumulator restarts so that the first line after reset follows R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| std_sel_i | input | 1 | Requested video standard, taken at frame wrap |
| interlace_i | input | 1 | Interlaced operation, taken at frame wrap |
| line_tick_o | output | 1 | One-cycle pulse at the end of each line |
| line_o | output | LINE_W | Current line number within the frame |
| vblank_irq_o | output | 1 | One-cycle vertical-blank interrupt pulse |
| field_o | output | 1 | Odd/even field flag |
| audio_tick_o | output | 1 | One-cycle audio-update pulse |

## Verification
The bench uses a reduced configuration: 5.25 and 6.5 clocks per line, 12 and 15 lines per frame, vertical blank at line 9, and an audio tick every 4 lines. It runs a cycle-exact arithmetic model next to the design over many frames.

The stimulus comes in phases:
- A quiet phase with a fixed standard checks fractional pacing on its own.
- Slow toggling of the select and interlace inputs produces frames in both standards and wraps that switch standard. These show whether the new increment is applied at the right line.
- A phase that flips the select input every cycle separates sampling only at wrap from sampling at any line.

Because the audio period of 4 is coprime to the frame lengths of 15 lines, the audio count runs across frame boundaries and reveals any restart of that count.

// File: rtl/scan_timing_pkg.sv
// Shared types for the scanline and frame timing generator.
package scan_timing_pkg;

    // Video standard selector; the value doubles as the std_sel_i encoding.
    typedef enum logic {
        STD_60 = 1'b0,
        STD_50 = 1'b1
    } vid_std_e;

endpackage

// File: rtl/line_phase_acc.sv
// Fractional line pacer.
// Counts clocks within a line and flags the last clock of the line. At each
// line end it adds the next line's fixed-point increment to the carried
// fraction: the integer part becomes the next line length and the fraction
// is kept.
// Assumes: every increment has an integer part of at least 2 and below
// 2^INT_W - 1, so line_end_o is never high in two consecutive cycles.
module line_phase_acc #(
    parameter int INT_W   = 12,
    parameter int FRAC_W  = 12,
    parameter int RST_INC = 8791293,
    localparam int ACC_W  = INT_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc_next_i,
    output logic             line_end_o
);

    localparam logic [ACC_W-1:0] RST_INC_V = ACC_W'(RST_INC);

    logic [INT_W-1:0]  pcnt_q;
    logic [INT_W-1:0]  len_q;
    logic [FRAC_W-1:0] frac_q;
    logic [ACC_W-1:0]  sum;

    // Next phase: carried fraction plus the increment of the coming line.
    assign sum        = {{INT_W{1'b0}}, frac_q} + inc_next_i;
    assign line_end_o = (pcnt_q == len_q - 1'b1);

    // Clock-in-line counter, next line length and carried fraction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            len_q  <= RST_INC_V[ACC_W-1:FRAC_W];
            frac_q <= RST_INC_V[FRAC_W-1:0];
        end else if (line_end_o) begin
            pcnt_q <= '0;
            len_q  <= sum[ACC_W-1:FRAC_W];
            frac_q <= sum[FRAC_W-1:0];
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/line_frame_ctr.sv
// Line and frame sequencer.
// Numbers the lines of the frame for the active standard and latches a new
// standard only at frame wrap. It supplies the increment for the coming
// line, pulses the vertical-blank interrupt, and keeps the field flag.
// Assumes: 0 < VBL_LINE < min(LINES_A, LINES_B); one line_end_i pulse per
// line.
module line_frame_ctr
    import scan_timing_pkg::*;
#(
    parameter int LINES_A  = 263,
    parameter int LINES_B  = 313,
    parameter int VBL_LINE = 240,
    parameter int FRAME_W  = 8,
    parameter int LINE_W   = 9,
    parameter int ACC_W    = 24,
    parameter int INC_A    = 8791293,
    parameter int INC_B    = 8864320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end_i,
    input  logic              std_sel_i,
    input  logic              interlace_i,
    output logic [LINE_W-1:0] line_o,
    output logic              field_o,
    output logic              vblank_o,
    output logic [ACC_W-1:0]  inc_next_o
);

    localparam logic [LINE_W-1:0] LAST_A = LINE_W'(LINES_A - 1);
    localparam logic [LINE_W-1:0] LAST_B = LINE_W'(LINES_B - 1);
    localparam logic [LINE_W-1:0] VBL_V  = LINE_W'(VBL_LINE);
    localparam logic [ACC_W-1:0]  INC_AV = ACC_W'(INC_A);
    localparam logic [ACC_W-1:0]  INC_BV = ACC_W'(INC_B);

    vid_std_e           std_q, std_next;
    logic [LINE_W-1:0]  line_q, line_next, last_line;
    logic [FRAME_W-1:0] frame_q, frame_inc;
    logic               wrap;

    // Frame boundary and the standard that governs the coming line.
    always_comb begin
        last_line  = (std_q == STD_60) ? LAST_A : LAST_B;
        wrap       = line_end_i && (line_q == last_line);
        std_next   = wrap ? vid_std_e'(std_sel_i) : std_q;
        inc_next_o = (std_next == STD_60) ? INC_AV : INC_BV;
        line_next  = wrap ? '0 : line_q + 1'b1;
        frame_inc  = frame_q + 1'b1;
    end

    // Line number, frame count, latched standard, field flag, vblank pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q   <= '0;
            frame_q  <= '0;
            std_q    <= STD_60;
            field_o  <= 1'b0;
            vblank_o <= 1'b0;
        end else begin
            vblank_o <= line_end_i && (line_next == VBL_V);
            if (line_end_i) begin
                line_q <= line_next;
                if (wrap) begin
                    frame_q <= frame_inc;
                    std_q   <= std_next;
                    field_o <= interlace_i & frame_inc[0];
                end else if (line_next == VBL_V) begin
                    field_o <= 1'b0;
                end
            end
        end
    end

    assign line_o = line_q;

endmodule

// File: rtl/audio_line_div.sv
// Audio update divider.
// Emits a one-cycle pulse in the cycle after every AUDIO_LINES-th line end.
// Its count runs freely across frames. A period of 1 degenerates to a
// registered copy of the line end.
// Assumes: AUDIO_LINES >= 1.
module audio_line_div #(
    parameter int AUDIO_LINES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_end_i,
    output logic tick_o
);

    generate
        if (AUDIO_LINES <= 1) begin : g_every_line
            // Period of one line: delay the line end by one register.
            always_ff @(posedge clk) begin
                if (!rst_n) tick_o <= 1'b0;
                else        tick_o <= line_end_i;
            end
        end else begin : g_counted
            localparam int CNT_W = $clog2(AUDIO_LINES);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(AUDIO_LINES - 1);
            logic [CNT_W-1:0] cnt_q;

            // Line counter modulo AUDIO_LINES and the pulse at its wrap.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    tick_o <= 1'b0;
                end else begin
                    tick_o <= line_end_i && (cnt_q == LAST);
                    if (line_end_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/scan_timing_gen.sv
// Scanline and frame timing generator, top level.
// Connects the fractional line pacer, the line/frame sequencer and the audio
// divider. All outputs are functions of registers only.
// Assumes: both increments have integer parts in [2, 2^INT_W - 2].
module scan_timing_gen #(
    parameter int FRAC_W      = 12,
    parameter int INT_W       = 12,
    parameter int INC_60      = 8791293,
    parameter int INC_50      = 8864320,
    parameter int LINES_60    = 263,
    parameter int LINES_50    = 313,
    parameter int VBL_LINE    = 240,
    parameter int AUDIO_LINES = 32,
    parameter int FRAME_W     = 8,
    localparam int ACC_W      = INT_W + FRAC_W,
    localparam int LINES_MAX  = (LINES_60 > LINES_50) ? LINES_60 : LINES_50,
    localparam int LINE_W     = $clog2(LINES_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              std_sel_i,
    input  logic              interlace_i,
    output logic              line_tick_o,
    output logic [LINE_W-1:0] line_o,
    output logic              vblank_irq_o,
    output logic              field_o,
    output logic              audio_tick_o
);

    logic [ACC_W-1:0] inc_next;
    logic             line_end;

    line_phase_acc #(
        .INT_W   (INT_W),
        .FRAC_W  (FRAC_W),
        .RST_INC (INC_60)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_next_i (inc_next),
        .line_end_o (line_end)
    );

    line_frame_ctr #(
        .LINES_A  (LINES_60),
        .LINES_B  (LINES_50),
        .VBL_LINE (VBL_LINE),
        .FRAME_W  (FRAME_W),
        .LINE_W   (LINE_W),
        .ACC_W    (ACC_W),
        .INC_A    (INC_60),
        .INC_B    (INC_50)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_end_i  (line_end),
        .std_sel_i   (std_sel_i),
        .interlace_i (interlace_i),
        .line_o      (line_o),
        .field_o     (field_o),
        .vblank_o    (vblank_irq_o),
        .inc_next_o  (inc_next)
    );

    audio_line_div #(
        .AUDIO_LINES (AUDIO_LINES)
    ) u_audio (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_end_i (line_end),
        .tick_o     (audio_tick_o)
    );

    assign line_tick_o = line_end;

endmodule

// File: rtl/scan_timing_chk.sv
// Protocol checker for scan_timing_gen, bound to every instance of it.
// Observes only the top-level ports.
module scan_timing_chk #(
    parameter int LINE_W    = 9,
    parameter int VBL_LINE  = 240,
    parameter int LINES_MAX = 313
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_tick,
    input logic [LINE_W-1:0] line,
    input logic              vblank_irq,
    input logic              field,
    input logic              audio_tick
);

    // R1: a line lasts at least two clocks, so ticks never touch.
    p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        line_tick |=> !line_tick);

    // R2: the line number holds between ticks.
    p_line_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(line));

    // R2: after a tick the line advances by one or wraps to zero.
    p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_tick |=> (line == $past(line) + 1'b1) || (line == '0));

    // R2: the line number stays inside the longest frame.
    p_line_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(line) < LINES_MAX);

    // R4: the interrupt only marks the start of the blanking line.
    p_irq_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |-> (int'(line) == VBL_LINE) && $past(line_tick));

    // R4: the interrupt is a single-cycle pulse.
    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |=> !vblank_irq);

    // R5: the field flag is low when blanking begins.
    p_field_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |-> !field);

    // R5: the field flag moves only on a line boundary.
    p_field_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(field));

    // R6: the audio pulse always follows a line tick.
    p_audio_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        audio_tick |-> $past(line_tick));

endmodule

bind scan_timing_gen scan_timing_chk #(
    .LINE_W    (LINE_W),
    .VBL_LINE  (VBL_LINE),
    .LINES_MAX (LINES_MAX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_tick  (line_tick_o),
    .line       (line_o),
    .vblank_irq (vblank_irq_o),
    .field      (field_o),
    .audio_tick (audio_tick_o)
);

// File: tb/scan_timing_gen_tb.sv
`timescale 1ns/1ps
// Cycle-exact model comparison over a reduced configuration.
module scan_timing_gen_tb;

    localparam int FRAC_W = 12;
    localparam int INT_W  = 4;
    localparam int INC0   = 5 * 4096 + 1024;   // 5.25 clocks per line
    localparam int INC1   = 6 * 4096 + 2048;   // 6.5 clocks per line
    localparam int LN0    = 12;
    localparam int LN1    = 15;
    localparam int VBL    = 9;
    localparam int AUD    = 4;
    localparam int FRW    = 3;
    localparam int LINE_W = 4;
    localparam int RUN    = 30000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic std_sel = 1'b0;
    logic intl = 1'b0;
    logic line_tick, vblank_irq, field, audio_tick;
    logic [LINE_W-1:0] line;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scan_timing_gen #(
        .FRAC_W (FRAC_W), .INT_W (INT_W), .INC_60 (INC0), .INC_50 (INC1),
        .LINES_60 (LN0), .LINES_50 (LN1), .VBL_LINE (VBL),
        .AUDIO_LINES (AUD), .FRAME_W (FRW)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .std_sel_i (std_sel), .interlace_i (intl),
        .line_tick_o (line_tick), .line_o (line), .vblank_irq_o (vblank_irq),
        .field_o (field), .audio_tick_o (audio_tick)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Watchdog: an overlong run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        longint s;
        longint t;
        int m_std, m_line, m_frame, m_acnt, m_field;
        int e_irq, e_aud;
        int ticks;
        int irqs;
        int std1_frames;
        ticks = 0;
        irqs = 0;
        std1_frames = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: state after reset, sampled before the first active edge.
        chk("R7", "line after reset", int'(line), 0);
        chk("R7", "tick after reset", int'(line_tick), 0);
        chk("R7", "irq after reset", int'(vblank_irq), 0);
        chk("R7", "field after reset", int'(field), 0);
        chk("R7", "audio after reset", int'(audio_tick), 0);
        rst_n = 1'b1;

        // Model state as seen in cycle 0 after reset.
        s = INC0;
        t = (s >>> FRAC_W) - 1;
        m_std = 0; m_line = 0; m_frame = 0; m_acnt = 0; m_field = 0;
        e_irq = 0; e_aud = 0;

        for (int c = 0; c < RUN; c++) begin
            int e_tick;
            if (c > 0) @(negedge clk);
            e_tick = (longint'(c) == t) ? 1 : 0;
            chk("R1", "line tick", int'(line_tick), e_tick);
            chk("R2", "line number", int'(line), m_line);
            chk("R4", "vblank pulse", int'(vblank_irq), e_irq);
            chk("R5", "field flag", int'(field), m_field);
            chk("R6", "audio tick", int'(audio_tick), e_aud);
            if (e_tick != 0) ticks++;
            if (e_irq != 0) irqs++;

            // Stimulus for the coming edge: quiet, slow toggling, then fast R3 toggling.
            if (c < 800) begin
                std_sel = 1'b0; intl = 1'b0;
            end else if (c < 20000) begin
                std_sel = ((c / 97) % 2) != 0;
                intl    = ((c / 211) % 2) != 0;
            end else begin
                std_sel = (c % 2) != 0;
                intl    = 1'b1;
            end

            // Advance the model across the coming edge.
            e_irq = 0;
            e_aud = 0;
            if (e_tick != 0) begin
                int last;
                last = (m_std == 0) ? LN0 - 1 : LN1 - 1;
                if (m_line == last) begin
                    m_std = int'(std_sel);
                    m_line = 0;
                    m_frame = (m_frame + 1) % (1 << FRW);
                    m_field = intl ? (m_frame % 2) : 0;
                    if (m_std == 1) std1_frames++;
                end else begin
                    m_line = m_line + 1;
                    if (m_line == VBL) m_field = 0;
                end
                e_irq = (m_line == VBL) ? 1 : 0;
                s = s + ((m_std == 0) ? INC0 : INC1);
                t = (s >>> FRAC_W) - 1;
                if (m_acnt == AUD - 1) begin
                    m_acnt = 0;
                    e_aud = 1;
                end else begin
                    m_acnt = m_acnt + 1;
                end
            end
        end

        // Sanity on stimulus coverage: both standards and many blanking pulses (R3, R4).
        chk("R3", "frames run in standard 1 nonzero", int'(std1_frames > 10), 1);
        chk("R4", "vblank pulses observed nonzero", int'(irqs > 100), 1);
        chk("R1", "line ticks observed nonzero", int'(ticks > 1000), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule